// File: doc/BRIEF.md
# Dual-Compare Timer Status Register

An 8-bit free-running up-counter with two compare registers and one status/control byte, all reached over a small CPU bus. When enabled, the counter advances once per clock. Three sticky event flags are held in the status byte:
- the counter reaching compare register B;
- the counter reaching compare register A;
- the counter wrapping from 0xFF to 0x00.

Only hardware can set a flag. Software clears one with a two-step handshake: it first reads the status byte while the flag is 1, which arms that flag. A later write of 0 to the flag then clears it.

The low nibble of the status byte is plain storage, exposed on an output for a downstream pin driver. Bit 4 is a reserved bit that always reads 1. A standby input brings the status byte back to its reset value without touching the counter or the compare registers.

Bus map:

| Address | Register | Access |
|---|---|---|
| 0 | Counter | Read-only |
| 1 | Compare A | Read/write |
| 2 | Compare B | Read/write |
| 3 | Status byte | See below |

Read data is combinational from the selected register. A write takes effect at the clock edge.

Top module: `dual_cmp_timer`

## Requirements
- R1: The status byte reads as {flag_b, flag_a, flag_ovf, 1, sel[3:0]}, bit 7 down to bit 0.
- R2: Reset, or any cycle with standby high, loads the status byte with 0x10: all flags, all arm bits and sel become 0. Standby overrides a same-cycle set event.
- R3: When count_en is high and the counter steps to a value equal to compare B (or compare A), that flag is 1 from the same clock edge on. The compare registers reset to 0xFF.
- R4: The overflow flag becomes 1 at the edge where an enabled counter steps from 0xFF to 0x00.
- R5: A status write with 1 in bits 7..5 never sets a flag.
- R6: A status write of 0 to a flag that has not been armed leaves the flag at 1.
- R7: A status read arms each flag that reads as 1. A following status write of 0 clears the armed flags. Any status write disarms all flags.
- R8: If a set event and a valid clear of the same flag fall in one cycle, the flag stays 1.
- R9: A status write stores bits 3..0 into sel, which drives ctl_sel. Bit 4 ignores writes and always reads 1.
- R10: The counter resets to 0, increments by one per cycle while count_en is high, holds otherwise, and reads at address 0. Compare registers read back at addresses 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| standby | input | 1 | Reinitialises the status byte |
| count_en | input | 1 | Counter advance enable |
| cpu_addr | input | 2 | Register select |
| cpu_rd | input | 1 | Read strobe (arms flags on status reads) |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data of the selected register |
| ctl_sel | output | 4 | Output-select bits |

## Verification
The hardest case to reach is a set event landing in the same cycle as an armed clear. Natural repeats of a match are 256 cycles apart. The stimulus therefore arms flag B, moves compare B one count ahead, and issues the clearing write in the very cycle the counter steps onto the new value. Long constrained-random runs then mix reads, writes, compare changes, enable toggling and rare standby pulses against a bench model of flags and arm bits. This covers unarmed clears, stale arms and disarm-by-write.

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       standby,
  input  logic       count_en,
  input  logic [1:0] cpu_addr,
  input  logic       cpu_rd,
  input  logic       cpu_wr,
  input  logic [7:0] cpu_wdata,
  output logic [7:0] cpu_rdata,
  output logic [3:0] ctl_sel
);
  localparam logic [7:0] CNT_MAX = 8'hFF;
  localparam logic [1:0] A_CNT = 2'd0, A_CMPA = 2'd1, A_CMPB = 2'd2, A_STAT = 2'd3;

  logic [7:0] cnt, cmp_a, cmp_b;
  logic [2:0] flg, arm;   // [2]=B, [1]=A, [0]=overflow
  logic [3:0] sel;

  wire [7:0] cnt_nx  = cnt + 8'd1;
  wire [2:0] hw_set  = {count_en && cnt_nx == cmp_b,
                        count_en && cnt_nx == cmp_a,
                        count_en && cnt == CNT_MAX};
  wire       stat_wr = cpu_wr && cpu_addr == A_STAT;
  wire       stat_rd = cpu_rd && cpu_addr == A_STAT;
  wire [2:0] sw_clr  = stat_wr ? (arm & ~cpu_wdata[7:5]) : 3'b000;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= 8'h00;
      cmp_a <= 8'hFF;
      cmp_b <= 8'hFF;
    end else begin
      if (count_en) cnt <= cnt_nx;
      if (cpu_wr && cpu_addr == A_CMPA) cmp_a <= cpu_wdata;
      if (cpu_wr && cpu_addr == A_CMPB) cmp_b <= cpu_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || standby) begin
      flg <= 3'b000;
      arm <= 3'b000;
      sel <= 4'h0;
    end else begin
      flg <= (flg & ~sw_clr) | hw_set;
      if (stat_wr) begin
        arm <= 3'b000;
        sel <= cpu_wdata[3:0];
      end else if (stat_rd) begin
        arm <= arm | flg;
      end
    end
  end

  always_comb begin
    case (cpu_addr)
      A_CNT:   cpu_rdata = cnt;
      A_CMPA:  cpu_rdata = cmp_a;
      A_CMPB:  cpu_rdata = cmp_b;
      default: cpu_rdata = {flg, 1'b1, sel};
    endcase
  end

  assign ctl_sel = sel;

  assert_no_sw_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((flg & ~$past(flg) & ~$past(hw_set)) == 3'b000));

  assert_clear_needs_arm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(standby)) |->
      ((~flg & $past(flg) & ~($past(arm) & {3{$past(stat_wr)}})) == 3'b000));

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(standby)) |-> ((flg & $past(hw_set)) == $past(hw_set)));

  assert_standby_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(standby)) |-> (flg == 3'b000 && arm == 3'b000 && sel == 4'h0));

  assert_bit4_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr == A_STAT) |-> cpu_rdata[4]);

  assert_ovf_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(standby) && $past(count_en) && $past(cnt) == CNT_MAX) |-> flg[0]);
endmodule

// File: tb/test_dual_cmp_timer.sv
module test_dual_cmp_timer;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       standby = 0, count_en = 0, cpu_rd = 0, cpu_wr = 0;
  logic [1:0] cpu_addr = 0;
  logic [7:0] cpu_wdata = 0;
  logic [7:0] cpu_rdata;
  logic [3:0] ctl_sel;

  dual_cmp_timer i_dual_cmp_timer (.*);

  always #10 clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [7:0] m_cnt, m_ca, m_cb;
  logic [2:0] m_flg, m_arm;
  logic [3:0] m_sel;

  function automatic logic [7:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: return m_cnt;
      2'd1: return m_ca;
      2'd2: return m_cb;
      default: return {m_flg, 1'b1, m_sel};
    endcase
  endfunction

  function automatic logic [2:0] m_set(input logic en);
    logic [7:0] n = m_cnt + 8'd1;
    return {en && n == m_cb, en && n == m_ca, en && m_cnt == 8'hFF};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cnt = 0; m_ca = 8'hFF; m_cb = 8'hFF; m_flg = 0; m_arm = 0; m_sel = 0;
  endtask

  task automatic cyc(input logic rd, input logic wr, input logic [1:0] a,
                     input logic [7:0] d, input logic en, input logic sb, input string req);
    logic [2:0] s;
    logic [2:0] clr;
    cpu_rd = rd; cpu_wr = wr; cpu_addr = a; cpu_wdata = d; count_en = en; standby = sb;
    #1;
    chk(req, cpu_rdata, m_read(a));
    chk("R9 ctl_sel", {4'h0, ctl_sel}, {4'h0, m_sel});
    @(posedge clk);
    s = m_set(en);
    clr = (wr && a == 2'd3) ? (m_arm & ~d[7:5]) : 3'b000;
    if (sb) begin
      m_flg = 0; m_arm = 0; m_sel = 0;
    end else begin
      m_flg = (m_flg & ~clr) | s;
      if (wr && a == 2'd3) begin m_arm = 0; m_sel = d[3:0]; end
      else if (rd && a == 2'd3) m_arm = m_arm | m_flg_prev(s, clr);
    end
    if (wr && a == 2'd1) m_ca = d;
    if (wr && a == 2'd2) m_cb = d;
    if (en) m_cnt = m_cnt + 8'd1;
    @(negedge clk);
  endtask

  // arming uses the flag value seen by the read (before this edge's update)
  logic [2:0] flg_before;
  function automatic logic [2:0] m_flg_prev(input logic [2:0] s, input logic [2:0] c);
    return flg_before;
  endfunction

  task automatic step(input logic rd, input logic wr, input logic [1:0] a,
                      input logic [7:0] d, input logic en, input logic sb, input string req);
    flg_before = m_flg;
    cyc(rd, wr, a, d, en, sb, req);
  endtask

  task automatic peek(input logic [1:0] a, input logic [7:0] exp, input string req);
    cpu_rd = 0; cpu_wr = 0; cpu_addr = a; count_en = 0; standby = 0;
    #1;
    chk(req, cpu_rdata, exp);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    peek(2'd3, 8'h10, "R2 reset status");
    peek(2'd1, 8'hFF, "R10 reset cmp_a");
    peek(2'd0, 8'h00, "R10 reset counter");
    step(0, 1, 2'd3, 8'hFF, 0, 0, "R5 write ones");
    peek(2'd3, 8'h1F, "R5 R9 ones write sets no flag");
    step(0, 1, 2'd1, 8'h03, 0, 0, "R10 cmp_a write");
    step(0, 1, 2'd2, 8'h06, 0, 0, "R10 cmp_b write");
    repeat (3) step(0, 0, 2'd0, 8'h00, 1, 0, "R10 count");
    peek(2'd0, 8'h03, "R10 counter after 3");
    peek(2'd3, 8'h5F, "R3 flag_a set on reach");
    step(0, 1, 2'd3, 8'h00, 0, 0, "R6 unarmed clear");
    peek(2'd3, 8'h50, "R6 flag_a kept");
    step(1, 0, 2'd3, 8'h00, 0, 0, "R7 arm read");
    step(0, 1, 2'd3, 8'h00, 0, 0, "R7 clear");
    peek(2'd3, 8'h10, "R7 flag_a cleared");
    repeat (3) step(0, 0, 2'd0, 8'h00, 1, 0, "R10 count");
    peek(2'd3, 8'h90, "R3 flag_b set on reach");
    step(1, 0, 2'd3, 8'h00, 0, 0, "R8 arm b");
    step(0, 1, 2'd2, 8'h07, 0, 0, "R8 move cmp_b");
    step(0, 1, 2'd3, 8'h00, 1, 0, "R8 clear during set");
    peek(2'd3, 8'h90, "R8 set wins");
    step(0, 1, 2'd3, 8'h00, 0, 0, "R7 disarmed write");
    peek(2'd3, 8'h90, "R7 disarmed by write");
    step(1, 0, 2'd3, 8'h00, 0, 0, "R7 arm");
    step(0, 1, 2'd3, 8'h0A, 0, 0, "R7 clear");
    peek(2'd3, 8'h1A, "R7 R9 cleared, sel stored");
    while (m_cnt != 8'h00) step(0, 0, 2'd0, 8'h00, 1, 0, "R10 run");
    peek(2'd3, 8'h3A, "R4 overflow flag");
    step(0, 0, 2'd0, 8'h00, 0, 1, "R2 standby");
    peek(2'd3, 8'h10, "R2 standby status");
    void'($urandom(32'd1234));
    for (int i = 0; i < 20000; i++) begin
      int op = $urandom_range(0, 9);
      logic [1:0] a = 2'($urandom_range(0, 3));
      logic [7:0] d = 8'($urandom);
      logic en = ($urandom_range(0, 3) != 0);
      logic sb = ($urandom_range(0, 99) == 0);
      if (op < 3)      step(1, 0, 2'd3, d, en, sb, "R1 R7 rand status read");
      else if (op < 5) step(0, 1, 2'd3, d, en, sb, "R5 R6 R7 rand status write");
      else if (op < 6) step(0, 1, a, d, en, sb, "R3 R10 rand write");
      else             step(1, 0, a, d, en, sb, "R3 R4 R8 rand read");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule